// File: doc/BRIEF.md
# Multislope Run-up Modulation Sequencer

This block sequences the digital side of an integrating converter. After a command carrying a cycle count, it first requests a residue-ADC reading with both reference switches open and waits for the acknowledge. It then runs the requested number of 16-clock modulation cycles. In each cycle a synchronized comparator sample picks one of two fixed duty patterns, and the block counts the cycles that took the comparator-high pattern. When the run-up ends, the block presents that count and requests a second residue reading.

Between conversions the block dithers the integrator around zero. Every few clocks it closes whichever reference drives the integrator back toward the comparator threshold. It leaves dither on the first clock after a command arrives.

Top module: `ms_runup_seq`

## Requirements
- R1: While reset is asserted and on the first clock after it, `cmd_ready` is 1 and `meas_active`, `res_req` and `result_valid` are 0; both reference outputs are 0 during reset.
- R2: The high-pattern counter is preset to all ones when a command is accepted and decrements once per modulation cycle that sampled the comparator high, so `result_count` equals the bitwise complement of that number of cycles, and it holds until the next command.
- R3: A modulation cycle is 16 clocks. On a comparator-high cycle `ref_pos` is 1 on the first clock only and `ref_neg` on the other 15. On a comparator-low cycle `ref_neg` is 1 on the last clock only and `ref_pos` on the other 15.
- R4: `meas_active` is 1 for exactly 16 times the commanded count of consecutive clocks, with a reference closed on every one of them, and 0 otherwise.
- R5: A conversion raises `res_req` once before and once after the run-up. Each request holds until `res_ack` is sampled 1, and while it holds both references are open and `meas_active` is 0.
- R6: In idle, the block closes `ref_neg` when the synchronized comparator is high and `ref_pos` when it is low, refreshing that choice every 4 clocks. An accepted command opens both references on the next clock.
- R7: `result_valid` is a one-clock pulse after the last modulation cycle. The second residue request starts on the following clock.
- R8: `ref_pos` and `ref_neg` are never 1 in the same clock.
- R9: A count of zero skips the run-up (no `meas_active` clock), still performs both residue handshakes, and reports all ones.
- R10: `cmd_ready` is 1 only in idle. A `cmd_valid` raised during a conversion is ignored and does not alter the run-up length.
- R11: The comparator passes through a two-flop synchronizer and is sampled on the first clock of each modulation cycle, so a comparator change inside a cycle does not alter that cycle's pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block is idle and accepts a command |
| cmd_cycles | input | CNT_W | Number of modulation cycles requested |
| comp_in | input | 1 | Asynchronous comparator; 1 means the integrator is above threshold |
| ref_pos | output | 1 | Closes the reference that raises the integrator |
| ref_neg | output | 1 | Closes the reference that lowers the integrator |
| meas_active | output | 1 | High throughout the run-up |
| res_req | output | 1 | Residue-ADC read request |
| res_ack | input | 1 | Residue-ADC read done |
| result_valid | output | 1 | One-clock strobe of the result |
| result_count | output | CNT_W | Complement of the high-pattern cycle count |

## Verification
The bench targets a zero count, which a design that decremented before testing would turn into a run-up of 65536 cycles. It holds a request unacknowledged while it pokes the command port, which a design that leaked references or accepted the poke would fail. A comparator that toggles in the middle of cycles checks that the chosen pattern stays fixed for the whole cycle and that the count matches the observed patterns. Idle checks with each comparator level catch an inverted dither polarity.

// File: rtl/ms_runup_pkg.sv
// Shared types for the run-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ms_runup_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, // dithering, accepts a command
        ST_PRE,  // first residue read, references open
        ST_RUN,  // modulation cycles
        ST_PUSH, // result strobe
        ST_POST  // second residue read
    } seq_state_e;
endpackage

// File: rtl/ms_runup_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; the input is a slow level, not a pulse.
module ms_runup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // shift the level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/ms_runup_phase.sv
// Position counter inside a modulation cycle; flags first and last clock.
// Assumes: PERIOD >= 2; the counter is held at zero while run is low.
module ms_runup_phase #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic first,
    output logic last
);
    localparam int PH_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

    logic [PH_W-1:0] phase;

    // advance and wrap while running, park at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run)      phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else                     phase <= phase + PH_W'(1);
    end

    assign first = run && (phase == '0);
    assign last  = run && (phase == PH_LAST);
endmodule

// File: rtl/ms_runup_seq.sv
// Run-up sequencer: residue handshake, comparator-chosen duty cycles,
// second handshake, and idle dither.
// Assumes: res_ack is a pulse answered only while res_req is high;
// comp_in high means the integrator sits above the threshold.
module ms_runup_seq
    import ms_runup_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int CYCLE_CLKS  = 16,
    parameter int DITHER_CLKS = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [CNT_W-1:0] cmd_cycles,
    input  logic             comp_in,
    output logic             ref_pos,
    output logic             ref_neg,
    output logic             meas_active,
    output logic             res_req,
    input  logic             res_ack,
    output logic             result_valid,
    output logic [CNT_W-1:0] result_count
);
    localparam int DW = (DITHER_CLKS > 2) ? $clog2(DITHER_CLKS) : 1;
    localparam logic [DW-1:0]    DITH_RELOAD = DW'(DITHER_CLKS - 1);
    localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);

    seq_state_e       state;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] hi_q;
    logic             dec_q;
    logic [DW-1:0]    dith_cnt;
    logic             dith_pos, dith_neg;
    logic             comp_s;
    logic             cyc_first, cyc_last;
    logic             sel_hi;

    ms_runup_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(comp_in), .q(comp_s)
    );

    ms_runup_phase #(.PERIOD(CYCLE_CLKS)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(state == ST_RUN),
        .first(cyc_first), .last(cyc_last)
    );

    // pattern choice: fresh sample on the first clock, latched after that
    assign sel_hi = cyc_first ? comp_s : dec_q;

    // conversion sequencing, cycle budget and high-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            left_q <= '0;
            hi_q   <= '1;
            dec_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (cmd_valid) begin
                    left_q <= cmd_cycles;
                    hi_q   <= '1;
                    state  <= ST_PRE;
                end
                ST_PRE: if (res_ack)
                    state <= (left_q == '0) ? ST_PUSH : ST_RUN;
                ST_RUN: begin
                    if (cyc_first) begin
                        dec_q <= comp_s;
                        if (comp_s) hi_q <= hi_q - ONE;
                    end
                    if (cyc_last) begin
                        if (left_q == ONE) state <= ST_PUSH;
                        left_q <= left_q - ONE;
                    end
                end
                ST_PUSH: state <= ST_POST;
                ST_POST: if (res_ack) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // idle dither: refresh the restoring reference every DITHER_CLKS clocks
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_IDLE || cmd_valid) begin
            dith_cnt <= '0;
            dith_pos <= 1'b0;
            dith_neg <= 1'b0;
        end else if (dith_cnt == '0) begin
            dith_cnt <= DITH_RELOAD;
            dith_pos <= !comp_s;
            dith_neg <= comp_s;
        end else begin
            dith_cnt <= dith_cnt - DW'(1);
        end
    end

    // output decode from state and cycle position
    always_comb begin
        ref_pos = 1'b0;
        ref_neg = 1'b0;
        if (state == ST_RUN) begin
            ref_pos = sel_hi ? cyc_first : !cyc_last;
            ref_neg = sel_hi ? !cyc_first : cyc_last;
        end else if (state == ST_IDLE) begin
            ref_pos = dith_pos;
            ref_neg = dith_neg;
        end
    end

    assign cmd_ready    = (state == ST_IDLE);
    assign meas_active  = (state == ST_RUN);
    assign res_req      = (state == ST_PRE) || (state == ST_POST);
    assign result_valid = (state == ST_PUSH);
    assign result_count = hi_q;
endmodule

// File: rtl/ms_runup_seq_chk.sv
// Port-level property checker for the run-up sequencer, bound to the top.
// Assumes: synchronous active-low reset.
module ms_runup_seq_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [CNT_W-1:0] cmd_cycles,
    input logic             comp_in,
    input logic             ref_pos,
    input logic             ref_neg,
    input logic             meas_active,
    input logic             res_req,
    input logic             res_ack,
    input logic             result_valid,
    input logic [CNT_W-1:0] result_count
);
    a_r8_refs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_pos && ref_neg));

    a_r5_open_during_req: assert property (@(posedge clk) disable iff (!rst_n)
        res_req |-> (!ref_pos && !ref_neg && !meas_active));

    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (res_req && !res_ack) |=> res_req);

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_active || res_req || result_valid) |-> !cmd_ready);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    a_r7_then_second_req: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> res_req);

    a_r4_ref_closed_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        meas_active |-> (ref_pos || ref_neg));

    a_r2_count_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && $past(cmd_ready) && !$past(cmd_valid)) |-> $stable(result_count));

    a_r6_accept_opens_refs: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!ref_pos && !ref_neg && res_req));
endmodule

bind ms_runup_seq ms_runup_seq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/ms_runup_seq_tb.sv
module ms_runup_seq_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [W-1:0] cmd_cycles = '0;
    logic         comp_in = 1'b0;
    logic         ref_pos, ref_neg, meas_active, res_req;
    logic         res_ack = 1'b0;
    logic         result_valid;
    logic [W-1:0] result_count;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // per-conversion observations
    int g_meas, g_pos, g_neg, g_hiwin, g_reqs, g_req_bad, g_ready_bad, g_order_bad, g_pulses;
    logic [W-1:0] g_res;
    bit toggle_comp = 1'b0;

    always #5 clk = ~clk;

    ms_runup_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_cycles(cmd_cycles), .comp_in(comp_in), .ref_pos(ref_pos),
        .ref_neg(ref_neg), .meas_active(meas_active), .res_req(res_req),
        .res_ack(res_ack), .result_valid(result_valid), .result_count(result_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one conversion of n cycles; optionally pokes cmd_valid during the first request
    task automatic convert(input int n, input bit poke);
        int req_wait = 0;
        int win_clk = 0;
        int win_pos = 0;
        int tclk = 0;
        bit prev_req = 1'b0;
        g_meas = 0; g_pos = 0; g_neg = 0; g_hiwin = 0; g_reqs = 0;
        g_req_bad = 0; g_ready_bad = 0; g_order_bad = 0; g_pulses = 0;
        @(negedge clk);
        cmd_cycles = W'(n);
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int it = 0; it < 20000; it++) begin
            res_ack = 1'b0;
            if (poke && req_wait == 2 && g_reqs == 1) begin
                cmd_cycles = W'(9);
                cmd_valid = 1'b0;
            end
            if (res_req) begin
                if (!prev_req) g_reqs++;
                if (ref_pos || ref_neg || meas_active) g_req_bad++;
                if (cmd_ready) g_ready_bad++;
                req_wait++;
                if (poke && req_wait == 1 && g_reqs == 1) begin
                    cmd_cycles = W'(9);
                    cmd_valid = 1'b1;
                end
                if (req_wait == 4) res_ack = 1'b1;
            end else begin
                req_wait = 0;
            end
            prev_req = res_req;
            if (meas_active) begin
                if (cmd_ready) g_ready_bad++;
                g_meas++;
                if (ref_pos) begin g_pos++; win_pos++; end
                if (ref_neg) g_neg++;
                win_clk++;
                if (win_clk == 16) begin
                    if (win_pos == 1) g_hiwin++;
                    win_clk = 0;
                    win_pos = 0;
                end
                if (toggle_comp) begin
                    tclk++;
                    if (tclk % 23 == 0) comp_in = ~comp_in;
                end
            end
            if (result_valid) begin
                g_pulses++;
                g_res = result_count;
                if (g_reqs != 1) g_order_bad++;
            end
            if (cmd_ready && g_reqs == 2 && !res_req) break;
            @(negedge clk);
        end
    endtask

    localparam int NV = 6;
    localparam int VN[NV] = '{3, 1, 5, 2, 8, 4};
    localparam bit VC[NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cmd_ready && !meas_active && !res_req && !result_valid && !ref_pos && !ref_neg,
            "R1 reset outputs", {cmd_ready, meas_active, res_req, result_valid, ref_pos, ref_neg}, 32);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !meas_active && !res_req && !result_valid,
            "R1 first clock", {cmd_ready, meas_active, res_req, result_valid}, 8);

        // table of constant-comparator conversions
        for (int i = 0; i < NV; i++) begin
            comp_in = VC[i];
            repeat (4) @(negedge clk);
            convert(VN[i], 1'b0);
            chk(g_res == ~W'(VC[i] ? VN[i] : 0), "R2 result", int'(g_res), int'(~W'(VC[i] ? VN[i] : 0)));
            chk(g_meas == 16 * VN[i], "R4 meas clocks", g_meas, 16 * VN[i]);
            chk(g_pos == (VC[i] ? 1 : 15) * VN[i], "R3 pos clocks", g_pos, (VC[i] ? 1 : 15) * VN[i]);
            chk(g_neg == (VC[i] ? 15 : 1) * VN[i], "R3 neg clocks", g_neg, (VC[i] ? 15 : 1) * VN[i]);
            chk(g_reqs == 2 && g_req_bad == 0, "R5 two clean requests", g_reqs * 100 + g_req_bad, 200);
            chk(g_pulses == 1 && g_order_bad == 0, "R7 result between requests", g_pulses * 100 + g_order_bad, 100);
            chk(g_ready_bad == 0, "R10 ready low while busy", g_ready_bad, 0);
        end

        // R9: zero count
        convert(0, 1'b0);
        chk(g_res == '1, "R9 zero count result", int'(g_res), 65535);
        chk(g_meas == 0, "R9 no run-up", g_meas, 0);
        chk(g_reqs == 2, "R9 both handshakes", g_reqs, 2);

        // R10: command poked during first request is ignored
        comp_in = 1'b1;
        repeat (4) @(negedge clk);
        convert(2, 1'b1);
        chk(g_meas == 32, "R10 poke ignored, length", g_meas, 32);
        chk(g_res == ~W'(2), "R10 poke ignored, result", int'(g_res), int'(~W'(2)));
        repeat (3) @(negedge clk);
        chk(!res_req && cmd_ready, "R10 no extra conversion", {res_req, cmd_ready}, 1);

        // R11 with R2: comparator toggling mid-cycle; count must match observed patterns
        toggle_comp = 1'b1;
        convert(10, 1'b0);
        toggle_comp = 1'b0;
        chk(g_res == ~W'(g_hiwin), "R11 pattern fixed per cycle", int'(g_res), int'(~W'(g_hiwin)));
        chk(g_pos + g_neg == 160, "R11 every run clock closed", g_pos + g_neg, 160);

        // R6: idle dither polarity
        comp_in = 1'b1;
        repeat (10) @(negedge clk);
        chk(ref_neg && !ref_pos, "R6 dither comp high", {ref_pos, ref_neg}, 1);
        comp_in = 1'b0;
        repeat (10) @(negedge clk);
        chk(ref_pos && !ref_neg, "R6 dither comp low", {ref_pos, ref_neg}, 2);
        // R6: command leaves dither on the next clock
        cmd_cycles = W'(1);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(res_req && !ref_pos && !ref_neg, "R6 leave dither", {res_req, ref_pos, ref_neg}, 4);
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
        chk(meas_active, "R4 run starts after ack", int'(meas_active), 1);
        repeat (16) @(negedge clk);
        chk(result_valid && !meas_active, "R7 strobe after last cycle", {result_valid, meas_active}, 2);
        @(negedge clk);
        chk(res_req, "R7 second request follows", int'(res_req), 1);
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
        chk(cmd_ready, "R5 back to idle after ack", int'(cmd_ready), 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule